// File: doc/BRIEF.md
# Timer Compare Match Output Unit

This block watches a free-running 16-bit timer value and a 16-bit compare value. When the two become equal, it acts on an output pin, raises an interrupt flag, or emits a trigger that resets the timer. A 4-bit mode code selects the action. The timer itself lives outside the block, and so does whatever consumes the trigger pulse.

Each pin-driving mode gives the pin a defined level on the first cycle it is selected. After that, matches move the pin. A pin-enable output tells the surrounding pad logic whether this unit owns the pin. When it does not, the pad falls back to general-purpose control.

All interfaces are plain level signals, sampled on every clock. There is no data stream, so no valid/ready handshake is involved. Every output is registered: the outputs show the effect of the inputs presented at a rising edge immediately after that edge.

Mode codes used by this block:

| Code | Action |
|------|--------|
| 0000 | off |
| 0001 | reserved, treated as off |
| 0010 | toggle |
| 1000 | set from low |
| 1001 | clear from high |
| 1010 | flag only |
| 1011 | special event |

Every other code belongs to functions outside this unit and is treated as off.

Top module: `cmp_match_unit`

## Requirements
- R1: After reset, and whenever the mode is off (0000), reserved (0001), or any code other than 0010, 1000, 1001, 1010 or 1011, all of the following are 0 one edge later: `pin_oe`, `pin_out`, `flag` and `sevt`.
- R2: A match event occurs on an edge where all of the following hold:
  - the timer equals the compare value;
  - the two were unequal at the previous edge;
  - the mode equals the mode of the previous edge.
  If the values stay equal, there is no further event until they have differed at least once.
- R3: Mode 0010 (toggle):
  - `pin_oe` is 1;
  - the pin is driven low on the first edge in the mode;
  - each match event inverts the pin.
- R4: Mode 1000 (set from low):
  - `pin_oe` is 1;
  - the pin is driven low on the first edge in the mode;
  - a match event drives it high.
- R5: Mode 1001 (clear from high):
  - `pin_oe` is 1;
  - the pin is driven high on the first edge in the mode;
  - a match event drives it low.
- R6: Mode 1010 (flag only): `pin_oe` and `pin_out` are 0, and a match event sets `flag`.
- R7: Mode 1011 (special event):
  - `pin_oe` is 0;
  - a match event sets `flag`;
  - a match event raises `sevt` for exactly one cycle, on the edge where the match is seen.
- R8: In the compare modes, `flag` behaves as follows:
  - it is set by any match event;
  - it stays set until `flag_clr` is high at an edge with no match event;
  - when a match event and `flag_clr` arrive at the same edge, the set wins.
  - `flag` is kept when switching between compare modes.
- R9: The first edge at which a new mode is seen never produces a match event, even if the timer equals the compare value there.
- R10: Switching directly from one pin-driving mode to another re-applies the initial pin level of the new mode on the first edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timer_val | input | 16 | Current timer count |
| cmp_val | input | 16 | Compare value |
| mode | input | 4 | Match action code |
| flag_clr | input | 1 | Clears the interrupt flag |
| pin_out | output | 1 | Pin drive level |
| pin_oe | output | 1 | High when the compare logic owns the pin |
| flag | output | 1 | Sticky match interrupt flag |
| sevt | output | 1 | One-cycle timer-reset trigger |

## Verification
The block holds only a few bits of state, and a fault in any of them shows at the ports within one or two edges:
- A stale copy of the previous equality shows up as a repeated or missing event. A repeat appears as an extra pin toggle or a second `sevt` pulse during a held match. A missing event appears as a pin that fails to move on the first equal cycle.
- A stale copy of the previous mode breaks the entry level of the pin, or lets a match fire on the entry edge. The R9 and R10 sequences expose this on the very next edge.
- The flag's set/clear priority shows up only on an edge that carries both a match and a clear, so the bench creates that case on purpose.

A behavioural model compares all four outputs after every edge.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam int MODE_W = 4;

  localparam logic [MODE_W-1:0] MC_OFF    = 4'b0000;
  localparam logic [MODE_W-1:0] MC_RSVD   = 4'b0001;
  localparam logic [MODE_W-1:0] MC_TOGGLE = 4'b0010;
  localparam logic [MODE_W-1:0] MC_SETHI  = 4'b1000;
  localparam logic [MODE_W-1:0] MC_CLRLO  = 4'b1001;
  localparam logic [MODE_W-1:0] MC_IRQ    = 4'b1010;
  localparam logic [MODE_W-1:0] MC_TRIG   = 4'b1011;

  // Modes in which a compare match has any effect
  function automatic logic is_cmp_mode(input logic [MODE_W-1:0] m);
    return (m == MC_TOGGLE) || (m == MC_SETHI) || (m == MC_CLRLO) ||
           (m == MC_IRQ)    || (m == MC_TRIG);
  endfunction

  // Modes in which the compare logic drives the pin
  function automatic logic owns_pin(input logic [MODE_W-1:0] m);
    return (m == MC_TOGGLE) || (m == MC_SETHI) || (m == MC_CLRLO);
  endfunction

  // Pin level applied on the first edge in a pin-driving mode
  function automatic logic entry_level(input logic [MODE_W-1:0] m);
    return (m == MC_CLRLO);
  endfunction
endpackage

// File: rtl/cmp_mode_track.sv
module cmp_mode_track
  import cmp_pkg::*;
#(
  parameter int MW = MODE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [MW-1:0] mode_i,
  output logic [MW-1:0] mode_q,
  output logic          entry,
  output logic          active
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MC_OFF;
    else        mode_q <= mode_i;
  end

  assign entry  = (mode_i != mode_q);
  assign active = is_cmp_mode(mode_i);
endmodule

// File: rtl/cmp_match_detect.sv
module cmp_match_detect #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] timer_val,
  input  logic [TW-1:0] cmp_val,
  input  logic          enable,
  output logic          hit
);
  logic eq_now;
  logic eq_q;

  assign eq_now = (timer_val == cmp_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eq_q <= 1'b0;
    else        eq_q <= eq_now;
  end

  // Only the first cycle of equality counts as a match
  assign hit = enable && eq_now && !eq_q;

  assert_once_per_match_R2: assert property (
    @(posedge clk) disable iff (!rst_n) hit |=> !hit
  );
endmodule

// File: rtl/cmp_pin_drive.sv
module cmp_pin_drive
  import cmp_pkg::*;
#(
  parameter int MW = MODE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [MW-1:0] mode_i,
  input  logic          entry,
  input  logic          hit,
  output logic          pin_out,
  output logic          pin_oe
);
  logic pin_nxt;

  always_comb begin
    pin_nxt = pin_out;
    if (!owns_pin(mode_i)) begin
      pin_nxt = 1'b0;
    end else if (entry) begin
      pin_nxt = entry_level(mode_i);
    end else if (hit) begin
      case (mode_i)
        MC_TOGGLE: pin_nxt = !pin_out;
        MC_SETHI:  pin_nxt = 1'b1;
        MC_CLRLO:  pin_nxt = 1'b0;
        default:   pin_nxt = pin_out;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_out <= 1'b0;
      pin_oe  <= 1'b0;
    end else begin
      pin_out <= pin_nxt;
      pin_oe  <= owns_pin(mode_i);
    end
  end

  assert_released_pin_low_R1: assert property (
    @(posedge clk) disable iff (!rst_n) !pin_oe |-> !pin_out
  );

  assert_set_sticks_R4: assert property (
    @(posedge clk) disable iff (!rst_n)
      (mode_i == MC_SETHI && !entry && pin_out) |=> pin_out
  );
endmodule

// File: rtl/cmp_event_gen.sv
module cmp_event_gen
  import cmp_pkg::*;
#(
  parameter int MW = MODE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [MW-1:0] mode_i,
  input  logic          active,
  input  logic          hit,
  input  logic          flag_clr,
  output logic          flag,
  output logic          sevt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      sevt <= 1'b0;
    end else begin
      if (!active)       flag <= 1'b0;
      else if (hit)      flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
      sevt <= hit && (mode_i == MC_TRIG);
    end
  end

  assert_sevt_single_R7: assert property (
    @(posedge clk) disable iff (!rst_n) sevt |=> !sevt
  );

  assert_sevt_sets_flag_R7: assert property (
    @(posedge clk) disable iff (!rst_n) sevt |-> flag
  );
endmodule

// File: rtl/cmp_match_unit.sv
module cmp_match_unit
  import cmp_pkg::*;
#(
  parameter int TW = 16,
  parameter int MW = MODE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] timer_val,
  input  logic [TW-1:0] cmp_val,
  input  logic [MW-1:0] mode,
  input  logic          flag_clr,
  output logic          pin_out,
  output logic          pin_oe,
  output logic          flag,
  output logic          sevt
);
  logic [MW-1:0] mode_q;
  logic          entry;
  logic          active;
  logic          hit;

  cmp_mode_track #(.MW(MW)) u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode_i (mode),
    .mode_q (mode_q),
    .entry  (entry),
    .active (active)
  );

  // A new mode never matches on its first edge
  cmp_match_detect #(.TW(TW)) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .timer_val (timer_val),
    .cmp_val   (cmp_val),
    .enable    (active && !entry),
    .hit       (hit)
  );

  cmp_pin_drive #(.MW(MW)) u_pin (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_i  (mode),
    .entry   (entry),
    .hit     (hit),
    .pin_out (pin_out),
    .pin_oe  (pin_oe)
  );

  cmp_event_gen #(.MW(MW)) u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_i   (mode),
    .active   (active),
    .hit      (hit),
    .flag_clr (flag_clr),
    .flag     (flag),
    .sevt     (sevt)
  );

  assert_off_quiet_R1: assert property (
    @(posedge clk) disable iff (!rst_n)
      !is_cmp_mode(mode_q) |-> (!flag && !sevt && !pin_oe)
  );

  assert_no_entry_event_R9: assert property (
    @(posedge clk) disable iff (!rst_n)
      (mode != mode_q) |=> !sevt
  );
endmodule

// File: tb/test_cmp_match_unit.sv
`timescale 1ns/1ps
module test_cmp_match_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] timer_val = '0;
  logic [15:0] cmp_val = '0;
  logic [3:0]  mode = '0;
  logic        flag_clr = 1'b0;
  logic        pin_out, pin_oe, flag, sevt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  cmp_match_unit i_cmp_match_unit (
    .clk(clk), .rst_n(rst_n), .timer_val(timer_val), .cmp_val(cmp_val),
    .mode(mode), .flag_clr(flag_clr), .pin_out(pin_out), .pin_oe(pin_oe),
    .flag(flag), .sevt(sevt)
  );

  // Behavioural reference model
  int m_prev_mode, m_prev_eq;
  bit m_pin, m_oe, m_flag, m_sevt;

  function automatic bit cmp_code(int m);
    return m == 2 || m == 8 || m == 9 || m == 10 || m == 11;
  endfunction
  function automatic bit drv_code(int m);
    return m == 2 || m == 8 || m == 9;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prev_mode = 0; m_prev_eq = 0;
      m_pin = 0; m_oe = 0; m_flag = 0; m_sevt = 0;
    end else begin
      int md;
      bit eq, fire;
      md   = int'(mode);
      eq   = (timer_val == cmp_val);
      fire = eq && (m_prev_eq == 0) && cmp_code(md) && (md == m_prev_mode);
      if (!drv_code(md))        m_pin = 0;
      else if (md != m_prev_mode) m_pin = (md == 9);
      else if (fire) begin
        if (md == 2) m_pin = !m_pin;
        else if (md == 8) m_pin = 1;
        else m_pin = 0;
      end
      m_oe = drv_code(md);
      if (!cmp_code(md)) m_flag = 0;
      else if (fire)     m_flag = 1;
      else if (flag_clr) m_flag = 0;
      m_sevt = fire && (md == 11);
      m_prev_eq = eq ? 1 : 0;
      m_prev_mode = md;
    end
  end

  task automatic chk(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_cmp();
    chk(pin_out, m_pin,  "R2 R3 R4 R5 R10 model pin_out");
    chk(pin_oe,  m_oe,   "R1 R3 R6 R7 model pin_oe");
    chk(flag,    m_flag, "R6 R7 R8 model flag");
    chk(sevt,    m_sevt, "R7 R9 model sevt");
  endtask

  // Compare at negedge, drive new inputs, wait for the edge, settle
  task automatic drive(input int t, input int c, input int m, input bit clr);
    @(negedge clk);
    model_cmp();
    timer_val = 16'(t); cmp_val = 16'(c); mode = 4'(m); flag_clr = clr;
    @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1: reset state
    chk(pin_oe, 0, "R1 reset pin_oe"); chk(flag, 0, "R1 reset flag");
    chk(sevt, 0, "R1 reset sevt");     chk(pin_out, 0, "R1 reset pin_out");

    // R4: set from low
    drive(0, 5, 8, 0);
    chk(pin_oe, 1, "R4 entry oe"); chk(pin_out, 0, "R4 entry low");
    drive(4, 5, 8, 0);
    drive(5, 5, 8, 0);
    chk(pin_out, 1, "R4 match high"); chk(flag, 1, "R8 flag set");

    // R10, R5: clear from high, entry while equal
    drive(5, 5, 9, 0);
    chk(pin_out, 1, "R10 entry high");
    drive(5, 5, 9, 1);
    chk(flag, 0, "R8 flag cleared"); chk(pin_out, 1, "R2 held equal no event");
    drive(6, 5, 9, 0);
    drive(5, 5, 9, 0);
    chk(pin_out, 0, "R5 match low"); chk(flag, 1, "R5 flag");

    // R3: toggle
    drive(5, 5, 2, 0);
    chk(pin_out, 0, "R3 entry low"); chk(pin_oe, 1, "R3 oe");
    drive(6, 5, 2, 0);
    drive(5, 5, 2, 0);
    chk(pin_out, 1, "R3 first toggle");
    for (int i = 0; i < 3; i++) begin
      drive(5, 5, 2, 0);
      chk(pin_out, 1, "R2 no retoggle while equal");
    end
    drive(7, 5, 2, 0);
    drive(5, 5, 2, 0);
    chk(pin_out, 0, "R3 second toggle");
    drive(6, 5, 2, 1);
    drive(5, 5, 2, 1);
    chk(flag, 1, "R8 set beats clear");

    // R6: flag only
    drive(0, 5, 10, 1);
    chk(pin_oe, 0, "R6 oe released"); chk(flag, 0, "R6 flag clear");
    drive(5, 5, 10, 0);
    chk(flag, 1, "R6 flag on match"); chk(pin_out, 0, "R6 pin low");

    // R7: special event
    drive(0, 9, 11, 1);
    drive(9, 9, 11, 0);
    chk(sevt, 1, "R7 pulse"); chk(flag, 1, "R7 flag"); chk(pin_oe, 0, "R7 oe");
    drive(9, 9, 11, 0);
    chk(sevt, 0, "R7 pulse one cycle");

    // R9: equality on entry edge
    drive(0, 9, 10, 1);
    drive(9, 9, 11, 0);
    chk(sevt, 0, "R9 no event on entry");
    drive(9, 9, 11, 0);
    chk(sevt, 0, "R9 no event after entry");

    // R1: off, reserved, foreign codes
    drive(9, 9, 0, 0);
    chk(pin_oe, 0, "R1 off oe"); chk(flag, 0, "R1 off flag");
    drive(3, 3, 1, 0);
    chk(flag, 0, "R1 reserved flag");
    drive(4, 3, 12, 0);
    drive(3, 3, 12, 0);
    chk(flag, 0, "R1 foreign flag"); chk(pin_oe, 0, "R1 foreign oe");

    // Mixed traffic against the model
    begin
      logic [15:0] lf = 16'hACE1;
      int codes[8] = '{0, 1, 2, 8, 9, 10, 11, 13};
      for (int n = 0; n < 600; n++) begin
        int md;
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        md = (lf[7:5] == 3'd0 || n % 40 != 0) ? int'(mode) : codes[lf[2:0]];
        if (n % 40 == 0) md = codes[lf[10:8]];
        drive(int'(lf[1:0]), 2, md, lf[9]);
      end
    end
    @(negedge clk);
    model_cmp();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule